// File: doc/BRIEF.md
# Sequential Floating-Point Adder with Double-Length Result

This unit adds or subtracts two 36-bit sign-magnitude floating-point words over several clock cycles. One operand is the accumulator word and the other is the storage-register word. The operand with the smaller characteristic is shifted right so the two fractions line up. The aligned fractions are combined into a 54-bit double-length fraction. The upper half is written to the accumulator result and the lower half to a second result word, here called the low word. The low word carries its own characteristic.

A pulse on `start_i` loads the operands and the mode bits. `sub_i` selects subtraction, which flips the sign of the storage-register operand. `norm_i` selects normalizing mode, in which the accumulator result is shifted left, one place per cycle, until its leading fraction bit is set. When the work is finished, `done_o` pulses high for one cycle. Both result words then hold their values until the next operation completes.

Top module: `fpa_unit`

## Requirements
- R1: A word is laid out as bit 35 = sign (1 = minus), bits 34:27 = characteristic, bits 26:0 = fraction, with bit 26 the most significant fraction bit. Before the fractions are combined, the operand with the smaller characteristic is shifted right by the difference in characteristics, and the result starts from the larger characteristic. Bits shifted out below bit 0 of the accumulator half move into the fraction of the low word.
- R2: In normalizing mode, while the accumulator fraction bit 26 is 0, the whole 54-bit result fraction shifts left one place and the characteristic drops by one for each shift. This continues until bit 26 is 1, so unnormalized inputs also give a normalized accumulator. The loop makes at most 54 shifts.
- R3: In non-normalizing mode, no left shift is done, so the accumulator fraction may end up with bit 26 = 0.
- R4: If adding the magnitudes carries out of the top fraction bit, the 54-bit fraction shifts right one place with the carry entering bit 26, and the characteristic goes up by one. This applies in both modes.
- R5: Subtraction is addition with the sign bit of the storage-register operand inverted.
- R6: The accumulator result and the low word both take the sign of the operand whose aligned magnitude is larger. When the signs are equal, they take the common sign.
- R7: For a nonzero result, the characteristic of the low word equals the accumulator characteristic minus 27, taken modulo 256. The fraction of the low word holds the lower 27 result bits and is never normalized.
- R8: If the whole 54-bit result fraction is zero, both output words become zero in their characteristic and fraction. Their sign is then the sign (after any R5 inversion) of the operand with the smaller characteristic. If the characteristics are equal, the sign is the accumulator operand's sign.
- R9: If the characteristic difference is 27 or more, the smaller operand is discarded. The larger operand's sign, characteristic and fraction pass to the accumulator result, and the low word has a zero fraction.
- R10: `done_o` is high for exactly one cycle per operation. Both outputs change only in that cycle and hold their values otherwise. A `start_i` received while an operation is in progress is ignored.
- R11: After reset, both output words are zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation with the present operands |
| sub_i | input | 1 | 1 = subtract the storage-register word |
| norm_i | input | 1 | 1 = normalizing mode |
| ac_i | input | 36 | Accumulator operand |
| sr_i | input | 36 | Storage-register operand |
| ac_o | output | 36 | Accumulator result (high half) |
| mq_o | output | 36 | Low-word result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The operand pairs cover several cases, each aimed at a different part of the datapath:
- Equal-characteristic additions that carry out, which exercise the right-shift fix-up.
- Small characteristic gaps, which show alignment into the accumulator half. A gap that pushes bits into the low word checks the low-word fraction and its characteristic offset.
- Unlike-sign pairs where either operand is larger, which separate the sign rule from the subtraction inversion. A case that borrows across the half boundary shows whether the left shift carries low bits upward.
- Gaps of exactly 27 and of more than 27, which separate the discard rule from ordinary alignment.
- Exact cancellation with equal and with unequal characteristics, which distinguish the two zero-sign choices.
- Tiny unnormalized inputs, which drive a long normalizing loop.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int CHAR_W_DEF = 8;
  localparam int FRAC_W_DEF = 27;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_NORM = 2'd2,
    ST_FIN  = 2'd3
  } fpa_state_e;
endpackage

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int CHAR_W = 8,
  parameter int FRAC_W = 27,
  localparam int DBL_W = 2 * FRAC_W
) (
  input  logic              a_sgn,
  input  logic [CHAR_W-1:0] a_chr,
  input  logic [FRAC_W-1:0] a_frc,
  input  logic              b_sgn,
  input  logic [CHAR_W-1:0] b_chr,
  input  logic [FRAC_W-1:0] b_frc,
  output logic              big_sgn,
  output logic [CHAR_W-1:0] big_chr,
  output logic [DBL_W-1:0]  big_x,
  output logic              sml_sgn,
  output logic [DBL_W-1:0]  sml_x,
  output logic              zero_sgn
);
  logic              a_wins;
  logic [CHAR_W-1:0] gap;
  logic [FRAC_W-1:0] sml_frc;

  always_comb begin
    a_wins  = (a_chr >= b_chr);
    big_sgn = a_wins ? a_sgn : b_sgn;
    big_chr = a_wins ? a_chr : b_chr;
    sml_sgn = a_wins ? b_sgn : a_sgn;
    sml_frc = a_wins ? b_frc : a_frc;
    big_x   = {(a_wins ? a_frc : b_frc), {FRAC_W{1'b0}}};
    gap     = a_wins ? (a_chr - b_chr) : (b_chr - a_chr);
    // far-apart operands: the smaller one drops out entirely
    if (int'(gap) >= FRAC_W) sml_x = '0;
    else                     sml_x = {sml_frc, {FRAC_W{1'b0}}} >> gap;
    // zero-result sign follows the smaller characteristic, ties to accumulator
    zero_sgn = (a_chr > b_chr) ? b_sgn : a_sgn;
  end
endmodule

// File: rtl/fpa_magadd.sv
module fpa_magadd #(
  parameter int DBL_W = 54
) (
  input  logic             x_sgn,
  input  logic [DBL_W-1:0] x,
  input  logic             y_sgn,
  input  logic [DBL_W-1:0] y,
  output logic [DBL_W:0]   res,
  output logic             res_sgn
);
  always_comb begin
    if (x_sgn == y_sgn) begin
      res     = {1'b0, x} + {1'b0, y};
      res_sgn = x_sgn;
    end else if (x >= y) begin
      res     = {1'b0, x - y};
      res_sgn = x_sgn;
    end else begin
      res     = {1'b0, y - x};
      res_sgn = y_sgn;
    end
  end
endmodule

// File: rtl/fpa_unit.sv
module fpa_unit #(
  parameter int CHAR_W  = fpa_pkg::CHAR_W_DEF,
  parameter int FRAC_W  = fpa_pkg::FRAC_W_DEF,
  localparam int WORD_W = 1 + CHAR_W + FRAC_W,
  localparam int DBL_W  = 2 * FRAC_W,
  localparam int CNT_W  = $clog2(DBL_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic              norm_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic [WORD_W-1:0] sr_i,
  output logic [WORD_W-1:0] ac_o,
  output logic [WORD_W-1:0] mq_o,
  output logic              done_o
);
  import fpa_pkg::*;

  localparam logic [CHAR_W-1:0] LOW_BIAS = CHAR_W'(FRAC_W);

  fpa_state_e        state_q, state_d;
  logic [WORD_W-1:0] opa_q, opa_d, opb_q, opb_d;
  logic              nrm_q, nrm_d;
  logic [DBL_W-1:0]  frac_q, frac_d;
  logic [CHAR_W-1:0] chr_q, chr_d;
  logic              sgn_q, sgn_d, zsgn_q, zsgn_d, zero_q, zero_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] ac_q, ac_d, mq_q, mq_d;
  logic              done_q, done_d;
  logic              busy;

  logic              big_sgn, sml_sgn, zero_sgn, sum_sgn;
  logic [CHAR_W-1:0] big_chr;
  logic [DBL_W-1:0]  big_x, sml_x;
  logic [DBL_W:0]    sum;

  fpa_align #(.CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_align (
    .a_sgn   (opa_q[WORD_W-1]),
    .a_chr   (opa_q[WORD_W-2:FRAC_W]),
    .a_frc   (opa_q[FRAC_W-1:0]),
    .b_sgn   (opb_q[WORD_W-1]),
    .b_chr   (opb_q[WORD_W-2:FRAC_W]),
    .b_frc   (opb_q[FRAC_W-1:0]),
    .big_sgn (big_sgn),
    .big_chr (big_chr),
    .big_x   (big_x),
    .sml_sgn (sml_sgn),
    .sml_x   (sml_x),
    .zero_sgn(zero_sgn)
  );

  fpa_magadd #(.DBL_W(DBL_W)) u_add (
    .x_sgn  (big_sgn),
    .x      (big_x),
    .y_sgn  (sml_sgn),
    .y      (sml_x),
    .res    (sum),
    .res_sgn(sum_sgn)
  );

  assign busy = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    opa_d   = opa_q;
    opb_d   = opb_q;
    nrm_d   = nrm_q;
    frac_d  = frac_q;
    chr_d   = chr_q;
    sgn_d   = sgn_q;
    zsgn_d  = zsgn_q;
    zero_d  = zero_q;
    cnt_d   = cnt_q;
    ac_d    = ac_q;
    mq_d    = mq_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        opa_d   = ac_i;
        opb_d   = {sr_i[WORD_W-1] ^ sub_i, sr_i[WORD_W-2:0]};
        nrm_d   = norm_i;
        state_d = ST_CALC;
      end
      ST_CALC: begin
        if (sum[DBL_W]) begin
          frac_d = sum[DBL_W:1];
          chr_d  = big_chr + 1'b1;
        end else begin
          frac_d = sum[DBL_W-1:0];
          chr_d  = big_chr;
        end
        sgn_d   = sum_sgn;
        zsgn_d  = zero_sgn;
        zero_d  = (sum == '0);
        cnt_d   = '0;
        state_d = (nrm_q && sum != '0) ? ST_NORM : ST_FIN;
      end
      ST_NORM: begin
        if (frac_q[DBL_W-1] || cnt_q == CNT_W'(DBL_W)) begin
          zero_d  = (frac_q == '0);
          state_d = ST_FIN;
        end else begin
          frac_d = {frac_q[DBL_W-2:0], 1'b0};
          chr_d  = chr_q - 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      ST_FIN: begin
        if (zero_q) begin
          ac_d = {zsgn_q, {(WORD_W-1){1'b0}}};
          mq_d = {zsgn_q, {(WORD_W-1){1'b0}}};
        end else begin
          ac_d = {sgn_q, chr_q, frac_q[DBL_W-1:FRAC_W]};
          mq_d = {sgn_q, chr_q - LOW_BIAS, frac_q[FRAC_W-1:0]};
        end
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      opa_q   <= '0;
      opb_q   <= '0;
      nrm_q   <= 1'b0;
      frac_q  <= '0;
      chr_q   <= '0;
      sgn_q   <= 1'b0;
      zsgn_q  <= 1'b0;
      zero_q  <= 1'b0;
      cnt_q   <= '0;
      ac_q    <= '0;
      mq_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      opa_q   <= opa_d;
      opb_q   <= opb_d;
      nrm_q   <= nrm_d;
      frac_q  <= frac_d;
      chr_q   <= chr_d;
      sgn_q   <= sgn_d;
      zsgn_q  <= zsgn_d;
      zero_q  <= zero_d;
      cnt_q   <= cnt_d;
      ac_q    <= ac_d;
      mq_q    <= mq_d;
      done_q  <= done_d;
    end
  end

  assign ac_o   = ac_q;
  assign mq_o   = mq_q;
  assign done_o = done_q;
endmodule

// File: rtl/fpa_unit_chk.sv
module fpa_unit_chk #(
  parameter int CHAR_W  = 8,
  parameter int FRAC_W  = 27,
  localparam int WORD_W = 1 + CHAR_W + FRAC_W,
  localparam int DBL_W  = 2 * FRAC_W,
  localparam int CNT_W  = $clog2(DBL_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_o,
  input logic [WORD_W-1:0] ac_o,
  input logic [WORD_W-1:0] mq_o,
  input logic              nrm_q,
  input logic [CNT_W-1:0]  cnt_q
);
  logic [CHAR_W-1:0] ac_chr, mq_chr;
  logic              ac_fz, mq_fz;
  assign ac_chr = ac_o[WORD_W-2:FRAC_W];
  assign mq_chr = mq_o[WORD_W-2:FRAC_W];
  assign ac_fz  = (ac_o[FRAC_W-1:0] == '0);
  assign mq_fz  = (mq_o[FRAC_W-1:0] == '0);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(ac_o) && $stable(mq_o)));
  p_ac_norm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && nrm_q && !ac_fz) |-> ac_o[FRAC_W-1]);
  p_same_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ac_o[WORD_W-1] == mq_o[WORD_W-1]));
  p_low_chr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(ac_fz && mq_fz)) |-> (mq_chr == ac_chr - CHAR_W'(FRAC_W)));
  p_zero_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ac_fz && mq_fz) |-> (ac_chr == '0 && mq_chr == '0));
  p_shift_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DBL_W));
endmodule

bind fpa_unit fpa_unit_chk #(.CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .done_o(done_o),
  .ac_o  (ac_o),
  .mq_o  (mq_o),
  .nrm_q (nrm_q),
  .cnt_q (cnt_q)
);

// File: tb/tb_fpa_unit.sv
module tb_fpa_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD = 200;

  typedef struct packed {
    logic [35:0] a;
    logic [35:0] b;
    logic        sub;
    logic        nrm;
    logic [35:0] ac;
    logic [35:0] mq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // R4 carry out: 1.0 + 1.0
    '{{1'b0,8'd129,27'h4000000}, {1'b0,8'd129,27'h4000000}, 1'b0, 1'b1,
      {1'b0,8'd130,27'h4000000}, {1'b0,8'd103,27'h0000000}, 4'd4},
    // R1 alignment by two places
    '{{1'b0,8'd128,27'h4000000}, {1'b0,8'd126,27'h4000000}, 1'b0, 1'b1,
      {1'b0,8'd128,27'h5000000}, {1'b0,8'd101,27'h0000000}, 4'd1},
    // R7 shifted-out bits land in the low word
    '{{1'b0,8'd128,27'h4000000}, {1'b0,8'd125,27'h0000007}, 1'b0, 1'b1,
      {1'b0,8'd128,27'h4000000}, {1'b0,8'd101,27'h7000000}, 4'd7},
    // R5 subtract then normalize by two
    '{{1'b0,8'd128,27'h4000000}, {1'b0,8'd128,27'h3000000}, 1'b1, 1'b1,
      {1'b0,8'd126,27'h4000000}, {1'b0,8'd99,27'h0000000}, 4'd5},
    // R3 same operands, non-normalizing
    '{{1'b0,8'd128,27'h4000000}, {1'b0,8'd128,27'h3000000}, 1'b1, 1'b0,
      {1'b0,8'd128,27'h1000000}, {1'b0,8'd101,27'h0000000}, 4'd3},
    // R6 storage operand larger and negative
    '{{1'b0,8'd128,27'h1000000}, {1'b1,8'd128,27'h4000000}, 1'b0, 1'b1,
      {1'b1,8'd127,27'h6000000}, {1'b1,8'd100,27'h0000000}, 4'd6},
    // R8 cancellation, equal characteristics -> accumulator sign
    '{{1'b1,8'd130,27'h4000000}, {1'b1,8'd130,27'h4000000}, 1'b1, 1'b1,
      {1'b1,8'd0,27'h0}, {1'b1,8'd0,27'h0}, 4'd8},
    // R8 cancellation, unequal characteristics -> smaller-characteristic sign
    '{{1'b0,8'd130,27'h1000000}, {1'b1,8'd128,27'h4000000}, 1'b0, 1'b1,
      {1'b1,8'd0,27'h0}, {1'b1,8'd0,27'h0}, 4'd8},
    // R9 gap of 40 discards the accumulator operand
    '{{1'b0,8'd100,27'h4000000}, {1'b0,8'd140,27'h5000000}, 1'b0, 1'b1,
      {1'b0,8'd140,27'h5000000}, {1'b0,8'd113,27'h0000000}, 4'd9},
    // R9 gap of exactly 27, opposite signs
    '{{1'b0,8'd150,27'h4000000}, {1'b1,8'd123,27'h7FFFFFF}, 1'b0, 1'b1,
      {1'b0,8'd150,27'h4000000}, {1'b0,8'd123,27'h0000000}, 4'd9},
    // R2 tiny unnormalized inputs, 25 left shifts
    '{{1'b0,8'd128,27'h0000001}, {1'b0,8'd128,27'h0000001}, 1'b0, 1'b1,
      {1'b0,8'd103,27'h4000000}, {1'b0,8'd76,27'h0000000}, 4'd2},
    // R2 borrow across halves, left shift pulls low bit up
    '{{1'b0,8'd128,27'h4000000}, {1'b1,8'd127,27'h0000001}, 1'b0, 1'b1,
      {1'b0,8'd127,27'h7FFFFFF}, {1'b0,8'd100,27'h0000000}, 4'd2},
    // R4 carry in non-normalizing mode
    '{{1'b0,8'd129,27'h4000000}, {1'b0,8'd129,27'h4000000}, 1'b0, 1'b0,
      {1'b0,8'd130,27'h4000000}, {1'b0,8'd103,27'h0000000}, 4'd4},
    // R5 negative minus negative
    '{{1'b1,8'd128,27'h4000000}, {1'b1,8'd126,27'h4000000}, 1'b1, 1'b1,
      {1'b1,8'd127,27'h6000000}, {1'b1,8'd100,27'h0000000}, 4'd5}
  };

  logic        clk, rst_n, start_i, sub_i, norm_i, done_o;
  logic [35:0] ac_i, sr_i, ac_o, mq_o;
  int          n_chk, n_fail;
  logic        timed_out;

  fpa_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i), .norm_i(norm_i),
    .ac_i(ac_i), .sr_i(sr_i), .ac_o(ac_o), .mq_o(mq_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [35:0] act, input logic [35:0] exp, input int req,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [35:0] a, input logic [35:0] b,
                        input logic sb, input logic nm);
    @(negedge clk);
    ac_i = a; sr_i = b; sub_i = sb; norm_i = nm; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    timed_out = 1'b0;
    while (done_o !== 1'b1 && k < WD) begin
      @(negedge clk);
      k++;
    end
    if (k >= WD) begin
      timed_out = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual no done expected done");
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; sub_i = 1'b0; norm_i = 1'b0;
    ac_i = '0; sr_i = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(ac_o, 36'h0, 11, "reset ac");
    check(mq_o, 36'h0, 11, "reset mq");
    check({35'h0, done_o}, 36'h0, 11, "reset done");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      launch(TBL[i].a, TBL[i].b, TBL[i].sub, TBL[i].nrm);
      wait_done();
      if (!timed_out) begin
        check(ac_o, TBL[i].ac, int'(TBL[i].req), $sformatf("vector %0d ac", i));
        check(mq_o, TBL[i].mq, int'(TBL[i].req), $sformatf("vector %0d mq", i));
      end
    end

    // R10 start during busy is ignored; done is one cycle; outputs hold
    @(negedge clk);
    ac_i = {1'b0,8'd128,27'h4000000}; sr_i = {1'b0,8'd126,27'h4000000};
    sub_i = 1'b0; norm_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    ac_i = {1'b1,8'd10,27'h0000003}; sr_i = {1'b1,8'd12,27'h0000005};
    sub_i = 1'b1; norm_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    if (!timed_out) begin
      check(ac_o, {1'b0,8'd128,27'h5000000}, 10, "busy start ignored ac");
      check(mq_o, {1'b0,8'd101,27'h0000000}, 10, "busy start ignored mq");
    end
    @(negedge clk);
    check({35'h0, done_o}, 36'h0, 10, "done one cycle");
    repeat (3) @(negedge clk);
    check(ac_o, {1'b0,8'd128,27'h5000000}, 10, "ac held");
    check(mq_o, {1'b0,8'd101,27'h0000000}, 10, "mq held");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule